// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits beside the CPU core of a small microcontroller. It owns the four control bits of the status word that select a low-power state: halt, crystal-off, fast-gate and sub-clock-gate. From those bits and the current clock-source selections it produces the run enable for the CPU and the enables for the fast internal oscillator and the slow crystal oscillator. It also produces three gated clocks: master, sub-system and auxiliary. Each clock is gated by a latch-based cell, so an enable can change only while its root clock is low.

Software changes the mode by writing the status word. When an interrupt is accepted, the block offers the current control bits for pushing onto the stack and then wakes the part. It clears halt, crystal-off and sub-clock-gate, and leaves fast-gate as it was. On return from interrupt, the popped word replaces the control bits. A handler that edited the stacked word therefore resumes in the mode it wrote. In the deepest mode all four bits are set and every clock stops. In that mode an external wake input acts as an interrupt acceptance.

The push output is a one-cycle valid strobe with no ready input. The core has to take the word in the same cycle, so no back-pressure is possible. The mode inputs are plain level or pulse pins.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset all four control bits are clear. The CPU run enable, both oscillator enables and all three gated clocks are active, and the push strobe is low.
- R2: A status write loads the control bits from the written word. Halt is bit 4, crystal-off is bit 5, fast-gate is bit 6 and sub-clock-gate is bit 7. The write takes effect at the next clock edge, and all other bits of the word are ignored.
- R3: While halt is set, the CPU run enable is low and the master clock is held low.
- R4: While sub-clock-gate is set, the sub-system clock is held low.
- R5: A source select of 0 chooses the fast oscillator and 1 chooses the slow crystal. The fast oscillator enable is low only when fast-gate is set and the fast oscillator feeds neither an enabled master clock nor an enabled sub-system clock.
- R6: The crystal enable is low only when crystal-off is set and the crystal feeds neither an enabled master clock nor an enabled sub-system clock. The auxiliary clock runs exactly when the crystal is enabled, so with all four bits set every clock and oscillator is off.
- R7: In a cycle with interrupt acceptance the push strobe is high. The push word then carries the current control bits at their R2 positions, with zeros elsewhere. At the next edge halt, crystal-off and sub-clock-gate clear, and fast-gate keeps its value.
- R8: A return from interrupt loads the control bits from the popped word at the next edge. A popped word that differs from the pushed one selects the new mode.
- R9: When events coincide, interrupt acceptance wins over return from interrupt, which wins over a status write.
- R10: With all four bits set, the wake input acts exactly like interrupt acceptance, including the push strobe. In any other state the wake input has no effect.
- R11: Each gated clock equals its root clock ANDed with an enable that is captured only while the root is low. A change of enable therefore first shows in the high phase that follows the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_wr_en_i | input | 1 | Status word write strobe |
| sr_wr_data_i | input | SR_W | Status word written by the core |
| mclk_sel_i | input | 1 | Master clock source: 0 fast, 1 crystal |
| sclk_sel_i | input | 1 | Sub-system clock source: 0 fast, 1 crystal |
| irq_take_i | input | 1 | Interrupt accepted, one-cycle pulse |
| reti_i | input | 1 | Return from interrupt, one-cycle pulse |
| reti_word_i | input | SR_W | Status word popped from the stack |
| wake_i | input | 1 | External wake for the deepest mode |
| mroot_clk_i | input | 1 | Master clock root before gating |
| sroot_clk_i | input | 1 | Sub-system clock root before gating |
| aroot_clk_i | input | 1 | Auxiliary clock root before gating |
| cpu_run_o | output | 1 | CPU run enable |
| fosc_en_o | output | 1 | Fast internal oscillator enable |
| xosc_en_o | output | 1 | Slow crystal oscillator enable |
| mclk_o | output | 1 | Gated master clock |
| sclk_o | output | 1 | Gated sub-system clock |
| aclk_o | output | 1 | Gated auxiliary clock |
| push_vld_o | output | 1 | Push word valid, one cycle |
| push_word_o | output | SR_W | Control bits to push, other bits zero |

## Verification
Status writes step through halt alone, halt with fast-gate, the three-bit mode and the all-bits mode under several source selections. These separate the conditional oscillator shutdown from a plain bit copy: the same bit pattern must stop an oscillator under one selection and keep it running under another. Interrupt entry from a mode with fast-gate set shows that only three bits are cleared. Returns with an unchanged popped word and with an edited one tell restore apart from a fixed exit mode. Coincident event pulses check the priority order, and wake pulses in and out of the deepest mode show the wake input's gating. The gated clocks are sampled in each high phase against the enables of the previous cycle, which exposes any gate that follows its enable too early.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // Clock source choice for the master and sub-system clocks.
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } clk_src_e;

  // The four mode bits as held by the controller.
  typedef struct packed {
    logic sgate;  // sub-system clock gated
    logic fgate;  // fast oscillator may stop
    logic xoff;   // crystal may stop
    logic halt;   // CPU and master clock stopped
  } lpm_bits_t;

  // Decoded enables.
  typedef struct packed {
    logic cpu_run;
    logic mclk_en;
    logic sclk_en;
    logic fosc_en;
    logic xosc_en;
    logic aclk_en;
  } lpm_en_t;

  localparam int unsigned NUM_GATES = 3;

endpackage

// File: rtl/lpm_ctl_regs.sv
module lpm_ctl_regs
  import lpm_pkg::*;
#(
  parameter int unsigned SR_W      = 16,
  parameter int unsigned HALT_POS  = 4,
  parameter int unsigned XOFF_POS  = 5,
  parameter int unsigned FGATE_POS = 6,
  parameter int unsigned SGATE_POS = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [SR_W-1:0] wr_data_i,
  input  logic            irq_take_i,
  input  logic            reti_i,
  input  logic [SR_W-1:0] pop_data_i,
  input  logic            wake_i,
  output lpm_bits_t       bits_o,
  output logic            push_vld_o,
  output logic [SR_W-1:0] push_word_o
);

  function automatic lpm_bits_t extract(input logic [SR_W-1:0] w);
    lpm_bits_t b;
    b.halt  = w[HALT_POS];
    b.xoff  = w[XOFF_POS];
    b.fgate = w[FGATE_POS];
    b.sgate = w[SGATE_POS];
    return b;
  endfunction

  function automatic logic [SR_W-1:0] place(input lpm_bits_t b);
    logic [SR_W-1:0] w;
    w = '0;
    w[HALT_POS]  = b.halt;
    w[XOFF_POS]  = b.xoff;
    w[FGATE_POS] = b.fgate;
    w[SGATE_POS] = b.sgate;
    return w;
  endfunction

  lpm_bits_t bits_q, bits_d, wr_bits, pop_bits;
  logic      deep, take;

  assign wr_bits  = extract(wr_data_i);
  assign pop_bits = extract(pop_data_i);
  assign deep     = &bits_q;
  // Wake from the deepest state is treated as an accepted interrupt.
  assign take     = irq_take_i | (wake_i & deep);

  always_comb begin
    bits_d = bits_q;
    if (take) begin
      bits_d.halt  = 1'b0;
      bits_d.sgate = 1'b0;
      bits_d.xoff  = 1'b0;
    end else if (reti_i) begin
      bits_d = pop_bits;
    end else if (wr_en_i) begin
      bits_d = wr_bits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  assign bits_o      = bits_q;
  assign push_vld_o  = take;
  assign push_word_o = take ? place(bits_q) : '0;

  // R7: entry clears three bits
  p_entry_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> (!bits_q.halt && !bits_q.sgate && !bits_q.xoff))
    else $error("entry did not clear mode bits");

  // R7: fast-gate survives entry
  p_fgate_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |=> (bits_q.fgate == $past(bits_q.fgate)))
    else $error("entry altered fast-gate");

  // R8: return loads popped word
  p_reti_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !irq_take_i && !wake_i) |=> (bits_q == $past(pop_bits)))
    else $error("return did not restore bits");

  // R2 / R9: write applies only when nothing outranks it
  p_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !reti_i && !irq_take_i && !wake_i) |=> (bits_q == $past(wr_bits)))
    else $error("write not applied");

  // R10: wake outside the deepest state leaves bits alone
  p_wake_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !deep && !irq_take_i && !reti_i && !wr_en_i) |=> $stable(bits_q))
    else $error("wake changed bits outside deepest mode");

endmodule

// File: rtl/lpm_enable_decode.sv
module lpm_enable_decode
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lpm_bits_t bits_i,
  input  clk_src_e  msel_i,
  input  clk_src_e  ssel_i,
  output lpm_en_t   en_o
);

  logic fast_needed, slow_needed;
  logic m_on, s_on;

  assign m_on = ~bits_i.halt;
  assign s_on = ~bits_i.sgate;

  // An oscillator is needed while it feeds a clock that is running.
  assign fast_needed = (m_on && (msel_i == SRC_FAST)) || (s_on && (ssel_i == SRC_FAST));
  assign slow_needed = (m_on && (msel_i == SRC_SLOW)) || (s_on && (ssel_i == SRC_SLOW));

  always_comb begin
    en_o.cpu_run = m_on;
    en_o.mclk_en = m_on;
    en_o.sclk_en = s_on;
    en_o.fosc_en = ~bits_i.fgate | fast_needed;
    en_o.xosc_en = ~bits_i.xoff  | slow_needed;
    en_o.aclk_en = en_o.xosc_en;
  end

  // R5: the fast oscillator feeding a running master clock stays on
  p_fast_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bits_i.halt && msel_i == SRC_FAST) |-> en_o.fosc_en)
    else $error("fast oscillator stopped under running master clock");

  // R6: the crystal feeding a running sub-system clock stays on
  p_slow_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bits_i.sgate && ssel_i == SRC_SLOW) |-> en_o.xosc_en)
    else $error("crystal stopped under running sub-system clock");

  // R6: deepest state leaves nothing running
  p_deep_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bits_i) |-> (!en_o.aclk_en && !en_o.fosc_en && !en_o.cpu_run && !en_o.sclk_en))
    else $error("deepest state left a clock running");

endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);

  logic en_s;
  logic en_lat;
  logic en_hi_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= (sh_q << 1) | SYNC_STAGES'(en_i);
      end
      assign en_s = sh_q[SYNC_STAGES-1];
    end else begin : g_direct
      assign en_s = en_i;
    end
  endgenerate

  // Transparent while the root clock is low, closed while it is high.
  always_latch begin
    if (!clk_i) en_lat = en_s;
  end

  assign gclk_o = clk_i & en_lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_hi_q <= 1'b1;
    else         en_hi_q <= en_lat;
  end

  // R11: the captured enable does not move during the high phase
  p_gate_hold_r11: assert property (@(negedge clk_i) disable iff (!rst_ni)
    en_lat == en_hi_q)
    else $error("gate enable moved while clock high");

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned SR_W        = 16,
  parameter int unsigned HALT_POS    = 4,
  parameter int unsigned XOFF_POS    = 5,
  parameter int unsigned FGATE_POS   = 6,
  parameter int unsigned SGATE_POS   = 7,
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sr_wr_en_i,
  input  logic [SR_W-1:0] sr_wr_data_i,
  input  logic            mclk_sel_i,
  input  logic            sclk_sel_i,
  input  logic            irq_take_i,
  input  logic            reti_i,
  input  logic [SR_W-1:0] reti_word_i,
  input  logic            wake_i,
  input  logic            mroot_clk_i,
  input  logic            sroot_clk_i,
  input  logic            aroot_clk_i,
  output logic            cpu_run_o,
  output logic            fosc_en_o,
  output logic            xosc_en_o,
  output logic            mclk_o,
  output logic            sclk_o,
  output logic            aclk_o,
  output logic            push_vld_o,
  output logic [SR_W-1:0] push_word_o
);

  lpm_bits_t            bits;
  lpm_en_t              en;
  logic [NUM_GATES-1:0] roots, gate_en, gated;

  lpm_ctl_regs #(
    .SR_W(SR_W), .HALT_POS(HALT_POS), .XOFF_POS(XOFF_POS),
    .FGATE_POS(FGATE_POS), .SGATE_POS(SGATE_POS)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (sr_wr_en_i),
    .wr_data_i   (sr_wr_data_i),
    .irq_take_i  (irq_take_i),
    .reti_i      (reti_i),
    .pop_data_i  (reti_word_i),
    .wake_i      (wake_i),
    .bits_o      (bits),
    .push_vld_o  (push_vld_o),
    .push_word_o (push_word_o)
  );

  lpm_enable_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bits_i (bits),
    .msel_i (clk_src_e'(mclk_sel_i)),
    .ssel_i (clk_src_e'(sclk_sel_i)),
    .en_o   (en)
  );

  assign roots   = {aroot_clk_i, sroot_clk_i, mroot_clk_i};
  assign gate_en = {en.aclk_en, en.sclk_en, en.mclk_en};

  generate
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      lpm_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk_i  (roots[g]),
        .rst_ni (rst_ni),
        .en_i   (gate_en[g]),
        .gclk_o (gated[g])
      );
    end
  endgenerate

  assign mclk_o    = gated[0];
  assign sclk_o    = gated[1];
  assign aclk_o    = gated[2];
  assign cpu_run_o = en.cpu_run;
  assign fosc_en_o = en.fosc_en;
  assign xosc_en_o = en.xosc_en;

  // R3: halted CPU never runs
  p_halt_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits.halt |-> !cpu_run_o)
    else $error("CPU runs while halted");

  // R7 / R10: push strobe accompanies every accepted interrupt
  p_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_i |-> push_vld_o)
    else $error("no push on interrupt");

endmodule

// File: tb/lpm_clk_ctrl_test.sv
`timescale 1ns/100ps
module lpm_clk_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        msel = 1'b0, ssel = 1'b0;
  logic        irq = 1'b0, reti = 1'b0, wake = 1'b0;
  logic [15:0] pop = '0;
  logic        cpu_run, fosc_en, xosc_en, mclk, sclk, aclk, push_vld;
  logic [15:0] push_word;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sr_wr_en_i(wr_en), .sr_wr_data_i(wr_data),
    .mclk_sel_i(msel), .sclk_sel_i(ssel), .irq_take_i(irq), .reti_i(reti),
    .reti_word_i(pop), .wake_i(wake), .mroot_clk_i(clk), .sroot_clk_i(clk),
    .aroot_clk_i(clk), .cpu_run_o(cpu_run), .fosc_en_o(fosc_en),
    .xosc_en_o(xosc_en), .mclk_o(mclk), .sclk_o(sclk), .aclk_o(aclk),
    .push_vld_o(push_vld), .push_word_o(push_word)
  );

  // Bench model: bits ordered {sgate, fgate, xoff, halt}
  typedef struct {
    logic [3:0] b;
    logic       ms;
    logic       ss;
  } rec_t;

  rec_t       exp_q[$];
  logic [3:0] model = '0;
  logic [3:0] mon_prev = '0;

  function automatic logic [3:0] unpack_w(input logic [15:0] w);
    return {w[7], w[6], w[5], w[4]};
  endfunction

  function automatic logic [15:0] pack_w(input logic [3:0] b);
    logic [15:0] w;
    w = '0;
    w[7] = b[3]; w[6] = b[2]; w[5] = b[1]; w[4] = b[0];
    return w;
  endfunction

  // returns {cpu, m, s, f, x, a}
  function automatic logic [5:0] en_fn(input logic [3:0] b, input logic ms, input logic ss);
    logic m, s, f, x;
    m = ~b[0];
    s = ~b[3];
    f = ~b[2] | (m & ~ms) | (s & ~ss);
    x = ~b[1] | (m & ms) | (s & ss);
    return {m, m, s, f, x, x};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks the push side, queues the expected state.
  task automatic cycle(input logic w, input logic [15:0] wd, input logic i, input logic r,
                       input logic [15:0] pw, input logic wk, input logic m, input logic s);
    logic take;
    rec_t rc;
    @(negedge clk);
    wr_en = w; wr_data = wd; irq = i; reti = r; pop = pw; wake = wk; msel = m; ssel = s;
    #0.5;
    take = i | (wk & (&model));
    chk("R7 R10 push_vld", {15'd0, push_vld}, {15'd0, take});
    if (take) chk("R7 push_word", push_word, pack_w(model));
    if (take)   model = {1'b0, model[2], 1'b0, 1'b0};
    else if (r) model = unpack_w(pw);
    else if (w) model = unpack_w(wd);
    rc.b = model; rc.ms = m; rc.ss = s;
    exp_q.push_back(rc);
    @(posedge clk);
    #0.2;
    wr_en = 1'b0; irq = 1'b0; reti = 1'b0; wake = 1'b0;
  endtask

  task automatic wr(input logic [15:0] wd, input logic m, input logic s);
    cycle(1'b1, wd, 1'b0, 1'b0, 16'h0, 1'b0, m, s);
  endtask

  // Monitor: compares enables after each edge and gated clocks against the prior state.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        rec_t rc;
        logic [5:0] e, g;
        rc = exp_q.pop_front();
        e = en_fn(rc.b, rc.ms, rc.ss);
        g = en_fn(mon_prev, rc.ms, rc.ss);
        chk("R3 cpu_run", {15'd0, cpu_run}, {15'd0, e[5]});
        chk("R5 fosc_en", {15'd0, fosc_en}, {15'd0, e[2]});
        chk("R6 xosc_en", {15'd0, xosc_en}, {15'd0, e[1]});
        chk("R11 R3 mclk", {15'd0, mclk}, {15'd0, g[4]});
        chk("R11 R4 sclk", {15'd0, sclk}, {15'd0, g[3]});
        chk("R11 R6 aclk", {15'd0, aclk}, {15'd0, g[0]});
        mon_prev = rc.b;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 cpu_run", {15'd0, cpu_run}, 16'd1);
    chk("R1 fosc_en", {15'd0, fosc_en}, 16'd1);
    chk("R1 xosc_en", {15'd0, xosc_en}, 16'd1);
    chk("R1 push_vld", {15'd0, push_vld}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 mclk high phase", {15'd0, mclk}, 16'd1);
    chk("R1 aclk high phase", {15'd0, aclk}, 16'd1);

    // R3: halt alone, both clocks from the fast oscillator
    wr(16'h0010, 1'b0, 1'b0);
    // R5: fast-gate set but the sub-system clock still uses the fast oscillator
    wr(16'h0050, 1'b0, 1'b0);
    // R4, R5: sub-system clock gated too, fast oscillator may stop
    wr(16'h00D0, 1'b0, 1'b0);
    // R5: sub-system clock moved to crystal, fast oscillator free
    wr(16'h0050, 1'b0, 1'b1);
    // R6: crystal-off but master clock uses the crystal
    wr(16'h0020, 1'b1, 1'b0);
    // R6: master halted, crystal unused, auxiliary clock stops
    wr(16'h0030, 1'b1, 1'b0);
    // R2: other bits ignored, bits 7..4 clear
    wr(16'hFF0F, 1'b0, 1'b0);
    // R10: wake outside deepest mode has no effect
    wr(16'h0040, 1'b0, 1'b0);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    // R6: deepest mode, everything off
    wr(16'h00F0, 1'b0, 1'b0);
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    // R10: wake from deepest mode acts as entry
    cycle(1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    // R7: entry from a three-bit mode keeps fast-gate
    wr(16'h00D0, 1'b0, 1'b1);
    cycle(1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    // R8: plain restore, then an edited stacked word
    cycle(1'b0, 16'h0, 1'b0, 1'b1, 16'h00D0, 1'b0, 1'b0, 1'b1);
    cycle(1'b0, 16'h0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    cycle(1'b0, 16'h0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1);
    // R9: entry beats return and write
    wr(16'h00B0, 1'b1, 1'b0);
    cycle(1'b1, 16'h00F0, 1'b1, 1'b1, 16'h00F0, 1'b0, 1'b1, 1'b0);
    // R9: return beats write
    cycle(1'b1, 16'h0010, 1'b0, 1'b1, 16'h0080, 1'b0, 1'b1, 1'b0);
    wr(16'h0000, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule